// File: doc/BRIEF.md
# Card Column Sequencer

This block stands in for a punched-card reader in front of a host-side reader adapter. Once a read is started it asks for card columns one at a time over a valid/ready handshake. Each accepted 12-bit column is placed on twelve registered row lines, where 1 means a hole and 0 means a space. A single emitter strobe of fixed width then marks the column. After the strobe falls the rows stay frozen for a fixed settle window, so the adapter has time to run its end-of-column check before the next column is requested.

A card is 80 columns long. After the last settle window the block raises `done` and puts every row line back to space. Two things abort a read: the reader losing `rdr_ready`, and a watchdog that trips when the next column does not arrive in time. On an abort the block sets a sticky `error`, clears the rows and goes back to idle. The watchdog stays cleared until the first column has been taken, so a slow start to a card can never time out.

Top module: `card_column_seq`

## Requirements
- R1: In idle, `start` with `rdr_ready` high makes `busy` 1, clears `done` and `error`, sets `col_index` to 0 and asserts `col_ready` from the next cycle. `start` with `rdr_ready` low is ignored.
- R2: A column is taken on a clock edge where `col_valid` and `col_ready` are both high. In the following cycle `row_out` equals that column, with bit i being row i and 1 meaning punched, and `emit_strobe` rises. `col_ready` is high only while the block waits for a column and `rdr_ready` is high.
- R3: `emit_strobe` stays high for exactly EMIT_W cycles (default 4), and `row_out` does not change during that time.
- R4: After `emit_strobe` falls, `row_out` holds and `col_ready` stays low for exactly SETTLE cycles (default 5). The next column is requested only after that.
- R5: While a column is requested, `col_index` equals the number of columns already completed in this card (0 to COLS-1).
- R6: When the settle window of column COLS-1 (default 80 columns in total) ends, `busy` falls, `done` rises and `row_out` returns to all zeros.
- R7: Whenever `busy` is low, `row_out` is all zeros (space) and `emit_strobe` is low. This includes the state after reset.
- R8: If `rdr_ready` is low in any cycle while `busy`, the next cycle shows `busy` 0, `error` 1 and `row_out` zero.
- R9: Once at least one column of the card has been taken, `timeout_limit` consecutive waiting cycles without `col_valid` abort the read, exactly as in R8. A `timeout_limit` of 0 turns the watchdog off.
- R10: While the first column of a card is awaited, the watchdog does not advance, so the read never times out before the first column.
- R11: `done` and `error` remain set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to read one card |
| rdr_ready | input | 1 | Reader ready level. A drop during a card aborts it |
| timeout_limit | input | TMO_W (16) | Watchdog limit in waiting cycles. 0 disables it |
| col_valid | input | 1 | Column data is offered |
| col_data | input | ROWS (12) | Column rows, 1 = punched |
| col_ready | output | 1 | Block is waiting for a column |
| row_out | output | ROWS (12) | Row (photocell) lines to the adapter |
| emit_strobe | output | 1 | Per-column emitter pulse |
| col_index | output | 7 | Index of the column being handled |
| busy | output | 1 | Card read in progress |
| done | output | 1 | Sticky: last card completed |
| error | output | 1 | Sticky: last card aborted |

## Verification
A phase counter that slips changes the width of `emit_strobe`, or the gap from its falling edge to `col_ready`. That shows up within one column, about ten cycles. A row register loaded at the wrong moment changes `row_out` while the strobe is high or during the settle window, so it is visible within the same column. A watchdog that is armed too early or misses its count either ends a slow first column with `error`, or moves the abort cycle away from exactly `timeout_limit` waiting cycles. A column counter that is off by one shows up as a wrong `col_index` on the next request, or as `done` arriving at the wrong column.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_EMIT   = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cs_phase_timer.sv
// Loadable down-counter that times the strobe and settle phases.
module cs_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cs_watchdog.sv
// Counts waiting cycles and fires at the programmed limit (0 = off).
module cs_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end

  assign fire = tick && (limit != '0) && (cnt == limit - W'(1));
endmodule

// File: rtl/card_column_seq.sv
module card_column_seq
  import cardseq_pkg::*;
#(
  parameter int ROWS   = 12,
  parameter int COLS   = 80,
  parameter int EMIT_W = 4,
  parameter int SETTLE = 5,
  parameter int TMO_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      rdr_ready,
  input  logic [TMO_W-1:0]          timeout_limit,
  input  logic                      col_valid,
  input  logic [ROWS-1:0]           col_data,
  output logic                      col_ready,
  output logic [ROWS-1:0]           row_out,
  output logic                      emit_strobe,
  output logic [$clog2(COLS)-1:0]   col_index,
  output logic                      busy,
  output logic                      done,
  output logic                      error
);
  localparam int IDX_W  = $clog2(COLS);
  localparam int PH_MAX = (EMIT_W > SETTLE) ? EMIT_W : SETTLE;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0]  EMIT_LD  = PH_W'(EMIT_W - 1);
  localparam logic [PH_W-1:0]  SETL_LD  = PH_W'(SETTLE - 1);
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(COLS - 1);

  seq_state_e      state;
  logic            accept, abort, ph_zero, ph_load, wd_fire, wd_tick, wd_clear;
  logic [PH_W-1:0] ph_val;

  assign col_ready = (state == ST_WAIT) && rdr_ready;
  assign accept    = col_ready && col_valid;

  // Phase timer: loaded for the strobe on accept, for the settle window when the strobe ends.
  assign ph_load = accept || ((state == ST_EMIT) && ph_zero);
  assign ph_val  = accept ? EMIT_LD : SETL_LD;

  cs_phase_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  // Watchdog advances only after the first column of the card has been taken.
  assign wd_clear = (state != ST_WAIT);
  assign wd_tick  = (state == ST_WAIT) && (col_index != '0) && !col_valid;

  cs_watchdog #(.W(TMO_W)) u_wdog (
    .clk(clk), .rst(rst), .clear(wd_clear), .tick(wd_tick),
    .limit(timeout_limit), .fire(wd_fire)
  );

  assign abort = (state != ST_IDLE) && (!rdr_ready || wd_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      row_out     <= '0;
      emit_strobe <= 1'b0;
      col_index   <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
    end else if (abort) begin
      state       <= ST_IDLE;
      row_out     <= '0;
      emit_strobe <= 1'b0;
      col_index   <= '0;
      busy        <= 1'b0;
      error       <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start && rdr_ready) begin
            state     <= ST_WAIT;
            busy      <= 1'b1;
            done      <= 1'b0;
            error     <= 1'b0;
            col_index <= '0;
          end
        end
        ST_WAIT: begin
          if (accept) begin
            row_out     <= col_data;
            emit_strobe <= 1'b1;
            state       <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (ph_zero) begin
            emit_strobe <= 1'b0;
            state       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (ph_zero) begin
            if (col_index == LAST_COL) begin
              state     <= ST_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              row_out   <= '0;
              col_index <= '0;
            end else begin
              col_index <= col_index + IDX_W'(1);
              state     <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int ROWS   = 12,
  parameter int COLS   = 80,
  parameter int SETTLE = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    rdr_ready,
  input logic                    col_valid,
  input logic                    col_ready,
  input logic [ROWS-1:0]         row_out,
  input logic                    emit_strobe,
  input logic [$clog2(COLS)-1:0] col_index,
  input logic                    busy,
  input logic                    done,
  input logic                    error
);
  localparam int QW = $clog2(SETTLE + 1);
  logic [QW-1:0] quiet;

  // Counts cycles since the strobe last fell.
  always_ff @(posedge clk) begin
    if (rst)                        quiet <= QW'(SETTLE);
    else if (emit_strobe)           quiet <= '0;
    else if (quiet < QW'(SETTLE))   quiet <= quiet + QW'(1);
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && rdr_ready) |=> (busy && !done && !error && col_index == '0));

  assert_emit_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(emit_strobe) |-> $past(col_ready && col_valid));

  assert_ready_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
    col_ready |-> busy);

  assert_rows_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(col_ready && col_valid)) |-> $stable(row_out));

  assert_settle_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (!emit_strobe && quiet < QW'(SETTLE)) |-> !col_ready);

  assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
    col_index < ($clog2(COLS))'(COLS));

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done) && !(done && error));

  assert_idle_space_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (row_out == '0 && !emit_strobe));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !rdr_ready) |=> (!busy && error && row_out == '0));

  assert_no_early_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && rdr_ready && col_index == '0) |=> busy);
endmodule

bind card_column_seq cs_checker #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rdr_ready(rdr_ready), .col_valid(col_valid),
  .col_ready(col_ready), .row_out(row_out), .emit_strobe(emit_strobe),
  .col_index(col_index), .busy(busy), .done(done), .error(error)
);

// File: tb/tb_card_column_seq.sv
module tb_card_column_seq;
  localparam int ROWS = 12, COLS = 80, EMIT_W = 4, SETTLE = 5, TMO_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, rdr_ready = 1'b0, col_valid = 1'b0;
  logic [TMO_W-1:0] timeout_limit = 16'd20;
  logic [ROWS-1:0]  col_data = '0;
  logic             col_ready, emit_strobe, busy, done, error;
  logic [ROWS-1:0]  row_out;
  logic [6:0]       col_index;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  card_column_seq #(.ROWS(ROWS), .COLS(COLS), .EMIT_W(EMIT_W), .SETTLE(SETTLE), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst(rst), .start(start), .rdr_ready(rdr_ready), .timeout_limit(timeout_limit),
    .col_valid(col_valid), .col_data(col_data), .col_ready(col_ready), .row_out(row_out),
    .emit_strobe(emit_strobe), .col_index(col_index), .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected column pattern: directed corners first, then random.
  function automatic logic [ROWS-1:0] pick_col(input int i);
    if (i == 0) return '1;
    if (i == 1) return '0;
    if (i == COLS - 1) return 12'hA5A;
    return ROWS'($urandom_range(4095, 0));
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(done == 1'b0 && error == 1'b0, "R1 flags cleared", int'({done, error}), 0);
    chk(col_index == 0, "R1 index zero", int'(col_index), 0);
    chk(col_ready == 1'b1, "R1 col_ready", int'(col_ready), 1);
  endtask

  task automatic send_col(input logic [ROWS-1:0] d, input int dly, input int idx);
    int n, g;
    repeat (dly) @(negedge clk);
    col_valid = 1'b1; col_data = d;
    while (!col_ready) @(negedge clk);
    chk(col_index == 7'(idx), "R5 col_index", int'(col_index), idx);
    @(negedge clk);
    col_valid = 1'b0; col_data = $urandom_range(4095, 0);
    chk(row_out == d, "R2 rows after accept", int'(row_out), int'(d));
    n = 0;
    while (emit_strobe && n < 50) begin
      if (row_out != d) chk(1'b0, "R3 rows during strobe", int'(row_out), int'(d));
      n++; @(negedge clk);
    end
    chk(n == EMIT_W, "R3 strobe width", n, EMIT_W);
    g = 0;
    while (!col_ready && busy && g < 50) begin
      if (row_out != d) chk(1'b0, "R4 rows during settle", int'(row_out), int'(d));
      g++; @(negedge clk);
    end
    chk(g == SETTLE, "R4 settle length", g, SETTLE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !error, "R7 reset flags", int'({busy, done, error}), 0);
    chk(row_out == '0 && !emit_strobe, "R7 reset rows space", int'(row_out), 0);

    // Start ignored while reader not ready.
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0, "R1 start ignored without ready", int'(busy), 0);

    // Card 1: long wait before first column must not time out.
    rdr_ready = 1'b1;
    do_start();
    repeat (3 * 20) @(negedge clk);
    chk(busy && !error, "R10 no timeout before first column", int'({busy, error}), 2);
    for (int i = 0; i < COLS; i++) send_col(pick_col(i), $urandom_range(5, 0), i);
    chk(done && !busy && !error, "R6 done after last column", int'({done, busy, error}), 4);
    chk(row_out == '0, "R6 rows space after card", int'(row_out), 0);
    repeat (7) @(negedge clk);
    chk(done == 1'b1, "R11 done sticky", int'(done), 1);

    // Card 2: watchdog disabled, long stall mid-card survives.
    timeout_limit = '0;
    do_start();
    chk(done == 1'b0, "R11 done cleared by start", int'(done), 0);
    for (int i = 0; i < COLS; i++) send_col(pick_col(i), (i == 10) ? 60 : $urandom_range(3, 0), i);
    chk(done && !error, "R9 limit zero disables watchdog", int'({done, error}), 2);

    // Card 3: stall after three columns must abort after exactly the limit.
    timeout_limit = 16'd20;
    do_start();
    for (int i = 0; i < 3; i++) send_col(pick_col(i), $urandom_range(4, 0), i);
    w = 0;
    while (busy && w < 100) begin @(negedge clk); w++; end
    chk(w == 20, "R9 timeout cycle count", w, 20);
    chk(error == 1'b1 && row_out == '0, "R9 timeout error and space", int'({error, row_out}), 4096);
    repeat (10) @(negedge clk);
    chk(error == 1'b1, "R11 error sticky", int'(error), 1);

    // Card 4: reader drops ready during a strobe.
    do_start();
    chk(error == 1'b0, "R11 error cleared by start", int'(error), 0);
    for (int i = 0; i < 5; i++) send_col(pick_col(i), $urandom_range(4, 0), i);
    col_valid = 1'b1; col_data = 12'hFFF;
    while (!col_ready) @(negedge clk);
    @(negedge clk); col_valid = 1'b0;
    chk(emit_strobe == 1'b1, "R2 strobe before drop", int'(emit_strobe), 1);
    rdr_ready = 1'b0;
    @(negedge clk);
    chk(!busy && error, "R8 abort on ready drop", int'({busy, error}), 1);
    chk(row_out == '0 && !emit_strobe, "R8 rows space after abort", int'(row_out), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule